// File: doc/BRIEF.md
# Three-Lane Serial-to-Parallel Receiver with Failsafe Outputs

This block turns three serial data lanes plus a forwarded frame clock back into one 21-bit parallel word per frame. Each lane carries seven bits per frame, sent least significant bit first. The block runs on a local sampling clock that gives a fixed number of ticks per bit (two by default). A rising edge of the forwarded frame clock marks the start of a frame. Each bit is strobed in the middle of its slot. The assembled word is presented on a parallel output together with a recovered output clock at the frame rate.

The upstream analog receivers supply one activity flag per lane and one for the frame clock. The block records which of these drops first and picks a failsafe response from that order. If the frame clock goes away first, or at the same moment as the data, the last presented word is frozen. If a data lane goes away while the clock is still present, every data output is driven high. An active-low power-down input overrides all of this: it drives the data low and parks the output clock high. After power-down, or after a loss of signal, fresh data is shown only once a full frame has been received.

Top module: `tri_lane_deser`

## Requirements
- R1: Lane l carries output bits 7*l through 7*l+6. The first bit strobed after a frame clock rising edge is the lowest of those bits, and each following bit is the next higher one.
- R2: Bit k of a frame is sampled once, on sampling tick 2*k+1 counted from the frame clock edge. A value present only on tick 2*k, the first tick of the slot, has no effect on the word.
- R3: A word sent in frame F is on the parallel output at the output-clock rising edge that falls two frame periods after the start of frame F. It stays there for one whole frame period.
- R4: While powered up, the output clock runs at the frame rate with a 50% duty cycle: high for 7 sampling ticks and low for 7.
- R5: In normal operation the parallel output changes only on the output-clock falling edge, half a frame before the rising edge at which it is to be strobed.
- R6: While the active-low power-down input is low, all 21 data outputs are driven to 0 and the output clock is held at 1. This takes effect within three sampling-clock edges of the input falling.
- R7: After power-down is released, the data outputs stay at 0 until one complete frame, started by a frame clock edge seen while powered up, has been received.
- R8: If any lane activity flag drops while the frame clock flag is still high, all data outputs go to 1 and stay there, even if the frame clock flag drops later.
- R9: If the frame clock flag drops before any lane flag, or in the same cycle as one, the last presented word is held, even if lane flags drop later.
- R10: When all activity flags are high again after a loss, the outputs keep their failsafe value until a complete new frame has been received. Normal updates then resume with the R3 latency.
- R11: Power-down overrides both failsafe responses: a block in the all-ones state that is powered down drives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, TPB ticks per serial bit |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pd_n | input | 1 | Active-low power-down |
| ser_in | input | 3 | Serial data lanes, one bit per lane |
| lane_ok | input | 3 | Per-lane activity flag, 1 while the lane is driven |
| fclk_in | input | 1 | Forwarded frame clock, rising edge marks bit 0 |
| fclk_ok | input | 1 | Activity flag of the forwarded frame clock |
| par_out | output | 21 | Parallel data word |
| clk_out | output | 1 | Recovered output clock at the frame rate |

## Verification
Two functions can meet in one cycle: clock-loss detection and data-loss detection. The bench clears both activity flags in the same sampling tick, right after a stream of frames. It judges the result by checking that the output freezes at the word presented before the loss, rather than going all ones. Power-down is also applied while the block is already in the all-ones failsafe state, and the bench confirms that the zeros of power-down win. It also checks that recovery afterwards waits for a complete frame.

// File: rtl/tld_pkg.sv
package tld_pkg;
  localparam int LANES_DEF = 3;
  localparam int BITS_DEF  = 7;
  localparam int TPB_DEF   = 2;

  typedef enum logic [1:0] {
    LINK_LIVE = 2'd0,
    LINK_HOLD = 2'd1,
    LINK_HIGH = 2'd2
  } link_e;
endpackage

// File: rtl/tld_frame_timer.sv
module tld_frame_timer #(
  parameter int BITS = 7,
  parameter int TPB  = 2,
  parameter int PW   = $clog2(BITS * TPB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          pd_on,
  input  logic          fclk_in,
  output logic [PW-1:0] t_o,
  output logic          done_o,
  output logic          upd_o,
  output logic          oclk_o
);
  localparam int FT     = BITS * TPB;
  localparam int HALFF  = FT / 2;
  localparam int LASTSB = (BITS - 1) * TPB + TPB / 2;

  logic          fclk_q1, fclk_q2;
  logic [PW-1:0] ph_q, ph_d;
  logic          seen_q, seen_d;
  logic          done_q, done_d;
  logic          oclk_q, oclk_d;
  logic          rise;
  logic [PW-1:0] t;

  // frame edge realigns the tick count; otherwise it free-runs
  always_comb begin
    rise   = fclk_q1 & ~fclk_q2;
    t      = rise ? '0 : ph_q;
    ph_d   = (t == PW'(FT - 1)) ? '0 : t + PW'(1);
    if (!arm)                     seen_d = 1'b0;
    else if (rise)                seen_d = 1'b1;
    else if (t == PW'(LASTSB))    seen_d = 1'b0;
    else                          seen_d = seen_q;
    done_d = arm & seen_q & (t == PW'(LASTSB));
    oclk_d = pd_on ? (t < PW'(HALFF)) : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fclk_q1 <= 1'b0;
      fclk_q2 <= 1'b0;
      ph_q    <= '0;
      seen_q  <= 1'b0;
      done_q  <= 1'b0;
      oclk_q  <= 1'b0;
    end else begin
      fclk_q1 <= fclk_in;
      fclk_q2 <= fclk_q1;
      ph_q    <= ph_d;
      seen_q  <= seen_d;
      done_q  <= done_d;
      oclk_q  <= oclk_d;
    end
  end

  assign t_o    = t;
  assign done_o = done_q;
  assign upd_o  = (t == PW'(HALFF));
  assign oclk_o = oclk_q;

  // R4: tick counter never leaves the frame
  p_phase_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q < PW'(FT));
  // R4: output clock holds its level through a powered, unaligned tick
  p_oclk_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_on && $past(pd_on) && !rise && ph_q != '0 && ph_q != PW'(HALFF) &&
     $past(ph_q) != '0 && $past(ph_q) != PW'(HALFF) && $past(!rise))
    |=> $stable(oclk_q));
endmodule

// File: rtl/tld_lane_capture.sv
module tld_lane_capture #(
  parameter int BITS = 7,
  parameter int TPB  = 2,
  parameter int PW   = $clog2(BITS * TPB)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            din,
  input  logic [PW-1:0]   t,
  output logic [BITS-1:0] word
);
  logic            din_q;
  logic [BITS-1:0] cap_q, cap_d;
  logic [BITS-1:0] strobe;

  // one strobe per bit, centred in its slot
  for (genvar k = 0; k < BITS; k++) begin : g_strobe
    assign strobe[k] = (t == PW'(k * TPB + TPB / 2));
  end

  always_comb begin
    cap_d = cap_q;
    for (int k = 0; k < BITS; k++) begin
      if (strobe[k]) cap_d[k] = din_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q <= 1'b0;
      cap_q <= '0;
    end else begin
      din_q <= din;
      cap_q <= cap_d;
    end
  end

  assign word = cap_q;

  // R2: at most one bit position is strobed per tick
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe));
endmodule

// File: rtl/tld_loss_monitor.sv
module tld_loss_monitor
  import tld_pkg::*;
#(
  parameter int LANES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_on,
  input  logic [LANES-1:0] lane_ok,
  input  logic             fclk_ok,
  output link_e            state_o
);
  logic [LANES-1:0] lok_q;
  logic             cok_q;
  link_e            st_q, st_d;
  logic             all_ok, data_gone, clk_gone;

  always_comb begin
    all_ok    = (&lok_q) & cok_q;
    data_gone = ~(&lok_q);
    clk_gone  = ~cok_q;
    st_d      = st_q;
    if (!pd_on) begin
      st_d = LINK_LIVE;
    end else begin
      unique case (st_q)
        LINK_LIVE: begin
          if (clk_gone)       st_d = LINK_HOLD;
          else if (data_gone) st_d = LINK_HIGH;
        end
        LINK_HOLD, LINK_HIGH: begin
          if (all_ok) st_d = LINK_LIVE;
        end
        default: st_d = LINK_LIVE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lok_q <= '0;
      cok_q <= 1'b0;
      st_q  <= LINK_LIVE;
    end else begin
      lok_q <= lane_ok;
      cok_q <= fclk_ok;
      st_q  <= st_d;
    end
  end

  assign state_o = st_q;

  // R8: all-ones state is kept while any flag is still low
  p_high_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LINK_HIGH && pd_on && !all_ok) |=> (st_q == LINK_HIGH));
  // R9: freeze state is kept even if data drops afterwards
  p_hold_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LINK_HOLD && pd_on && !all_ok) |=> (st_q == LINK_HOLD));
endmodule

// File: rtl/tri_lane_deser.sv
module tri_lane_deser
  import tld_pkg::*;
#(
  parameter  int LANES = LANES_DEF,
  parameter  int BITS  = BITS_DEF,
  parameter  int TPB   = TPB_DEF,
  localparam int WORD  = LANES * BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_n,
  input  logic [LANES-1:0] ser_in,
  input  logic [LANES-1:0] lane_ok,
  input  logic             fclk_in,
  input  logic             fclk_ok,
  output logic [WORD-1:0]  par_out,
  output logic             clk_out
);
  localparam int PW = $clog2(BITS * TPB);

  logic            rst_r1, rst_s;
  logic            pd_q;
  logic [PW-1:0]   t;
  logic            done, upd, oclk;
  link_e           state;
  logic            arm;
  logic [WORD-1:0] lane_word;
  logic [WORD-1:0] stage_q, stage_d;
  logic            valid_q, valid_d;
  logic [WORD-1:0] dout_q, dout_d;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_r1 <= 1'b0;
      rst_s  <= 1'b0;
    end else begin
      rst_r1 <= 1'b1;
      rst_s  <= rst_r1;
    end
  end

  assign arm = pd_q & (state == LINK_LIVE);

  tld_frame_timer #(.BITS(BITS), .TPB(TPB), .PW(PW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_s),
    .arm     (arm),
    .pd_on   (pd_q),
    .fclk_in (fclk_in),
    .t_o     (t),
    .done_o  (done),
    .upd_o   (upd),
    .oclk_o  (oclk)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    tld_lane_capture #(.BITS(BITS), .TPB(TPB), .PW(PW)) u_cap (
      .clk   (clk),
      .rst_n (rst_s),
      .din   (ser_in[l]),
      .t     (t),
      .word  (lane_word[l*BITS +: BITS])
    );
  end

  tld_loss_monitor #(.LANES(LANES)) u_loss (
    .clk     (clk),
    .rst_n   (rst_s),
    .pd_on   (pd_q),
    .lane_ok (lane_ok),
    .fclk_ok (fclk_ok),
    .state_o (state)
  );

  always_comb begin
    stage_d = done ? lane_word : stage_q;
    if (!arm)      valid_d = 1'b0;
    else if (done) valid_d = 1'b1;
    else           valid_d = valid_q;
    if (!pd_q)                                        dout_d = '0;
    else if (state == LINK_HIGH)                      dout_d = {WORD{1'b1}};
    else if (state == LINK_LIVE && valid_q && upd)    dout_d = stage_q;
    else                                              dout_d = dout_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      pd_q    <= 1'b0;
      stage_q <= '0;
      valid_q <= 1'b0;
      dout_q  <= '0;
    end else begin
      pd_q    <= pd_n;
      stage_q <= stage_d;
      valid_q <= valid_d;
      dout_q  <= dout_d;
    end
  end

  assign par_out = dout_q;
  assign clk_out = oclk;

  // R5: live data moves only together with the output clock falling
  p_dout_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_s)
    (pd_q && $past(pd_q) && state == LINK_LIVE && $past(state) == LINK_LIVE &&
     dout_q != $past(dout_q)) |-> (!oclk && $past(oclk)));
  // R9: frozen word does not move
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_s)
    (pd_q && $past(pd_q) && state == LINK_HOLD && $past(state) == LINK_HOLD)
    |-> $stable(dout_q));
  // R6: sustained power-down gives zero data and a high clock
  p_pd_low_r6: assert property (@(posedge clk) disable iff (!rst_s)
    (!pd_n && $past(!pd_n)) |=> (par_out == '0 && clk_out));
endmodule

// File: tb/tri_lane_deser_bench.sv
module tri_lane_deser_bench;
  localparam int BITS = 7;
  localparam int TPB  = 2;
  localparam int FT   = BITS * TPB;
  localparam logic [20:0] ONES = 21'h1FFFFF;

  logic        clk = 1'b0;
  logic        rst_n, pd_n, fclk_in, fclk_ok;
  logic [2:0]  ser_in, lane_ok;
  logic [20:0] par_out;
  logic        clk_out;

  int total = 0;
  int bad   = 0;
  int fidx  = 0;
  logic [20:0] sent [0:63];
  logic [20:0] got2 [0:63];
  logic [20:0] got9 [0:63];
  int          hi   [0:63];

  always #5 clk = ~clk;

  tri_lane_deser u_tri_lane_deser (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .ser_in(ser_in), .lane_ok(lane_ok),
    .fclk_in(fclk_in), .fclk_ok(fclk_ok), .par_out(par_out), .clk_out(clk_out)
  );

  task automatic check(input string tag, input logic [20:0] act, input logic [20:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one frame: bit k of lane l = w[7*l+k], frame clock high for the first half
  task automatic send_frame(input logic [20:0] w, input bit glitch);
    int h = 0;
    for (int j = 0; j < FT; j++) begin
      @(negedge clk);
      if (j == 2) got2[fidx] = par_out;
      if (j == 9) got9[fidx] = par_out;
      if (clk_out) h++;
      for (int l = 0; l < 3; l++)
        ser_in[l] = w[l*BITS + j/TPB] ^ (glitch && (j % TPB == 0));
      fclk_in = (j < FT/2);
    end
    sent[fidx] = w;
    hi[fidx]   = h;
    fidx++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ser_in  = ser_in ^ 3'b101;
      fclk_in = 1'b0;
    end
  endtask

  task automatic t_reset;
    check("R6 reset data low", par_out, '0);
    check("R6 reset clock high", {20'd0, clk_out}, 21'd1);
  endtask

  task automatic t_stream;
    int b;
    logic [20:0] w [0:5];
    w[0] = 21'h000001; w[1] = 21'h000040; w[2] = 21'h000080;
    w[3] = 21'h100000; w[4] = 21'h155555; w[5] = 21'h0AAAAA;
    pd_n = 1'b1;
    idle(3);
    b = fidx;
    for (int i = 0; i < 6; i++) send_frame(w[i], 1'b0);
    send_frame('0, 1'b0);
    send_frame('0, 1'b0);
    check("R7 low after release f0", got2[b], '0);
    check("R7 low after release f1", got2[b+1], '0);
    check("R7 low at first fall", got9[b], '0);
    for (int i = 0; i < 6; i++) begin
      check("R1 R3 word at rising edge", got2[b+2+i], sent[b+i]);
      check("R5 word after falling edge", got9[b+1+i], sent[b+i]);
    end
    check("R4 clock high ticks", 21'(hi[b+3]), 21'd7);
    check("R4 clock high ticks next", 21'(hi[b+4]), 21'd7);
  endtask

  task automatic t_glitch;
    int b;
    b = fidx;
    send_frame(21'h1B2C3D, 1'b1);
    send_frame(21'h000000, 1'b0);
    send_frame(21'h000000, 1'b0);
    check("R2 first half of slot ignored", got2[b+2], 21'h1B2C3D);
  endtask

  task automatic t_hold_clock_first;
    int b, b2;
    b = fidx;
    send_frame(21'h0F0F0F, 1'b0);
    send_frame(21'h123456, 1'b0);
    send_frame(21'h0ABCDE, 1'b0);
    fclk_ok = 1'b0;
    idle(30);
    check("R9 clock lost holds word", par_out, sent[b+1]);
    lane_ok = 3'b000;
    idle(10);
    check("R9 later data loss still holds", par_out, sent[b+1]);
    lane_ok = 3'b111;
    fclk_ok = 1'b1;
    idle(4);
    b2 = fidx;
    for (int i = 0; i < 4; i++) send_frame(21'(21'h031415 + i * 21'h010203), 1'b0);
    check("R10 held until full frame", got2[b2+1], sent[b+1]);
    check("R10 resume word0", got2[b2+2], sent[b2]);
    check("R10 resume word1", got2[b2+3], sent[b2+1]);
  endtask

  task automatic t_data_first;
    send_frame(21'h055AA5, 1'b0);
    send_frame(21'h0C3C3C, 1'b0);
    lane_ok[1] = 1'b0;
    idle(6);
    check("R8 data lost gives ones", par_out, ONES);
    fclk_ok = 1'b0;
    idle(20);
    check("R8 later clock loss keeps ones", par_out, ONES);
  endtask

  task automatic t_pd_override;
    int b;
    pd_n = 1'b0;
    idle(4);
    check("R11 power-down beats ones", par_out, '0);
    check("R6 clock high in power-down", {20'd0, clk_out}, 21'd1);
    lane_ok = 3'b111;
    fclk_ok = 1'b1;
    idle(3);
    pd_n = 1'b1;
    idle(3);
    b = fidx;
    for (int i = 0; i < 4; i++) send_frame(21'(21'h1E0F01 - i * 21'h001111), 1'b0);
    check("R7 low in first frame", got2[b], '0);
    check("R7 low in second frame", got2[b+1], '0);
    check("R7 first word after release", got2[b+2], sent[b]);
    check("R3 second word after release", got2[b+3], sent[b+1]);
  endtask

  task automatic t_simultaneous;
    int b;
    b = fidx;
    send_frame(21'h111111, 1'b0);
    send_frame(21'h0EDCBA, 1'b0);
    send_frame(21'h1A1A1A, 1'b0);
    lane_ok = 3'b000;
    fclk_ok = 1'b0;
    idle(20);
    check("R9 same-cycle loss holds word", par_out, sent[b+1]);
  endtask

  initial begin
    rst_n = 1'b0; pd_n = 1'b0; fclk_in = 1'b0; fclk_ok = 1'b1;
    lane_ok = 3'b111; ser_in = 3'b000;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_stream();
    t_glitch();
    t_hold_clock_first();
    t_data_first();
    t_pd_override();
    t_simultaneous();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule